// File: doc/BRIEF.md
# Auto-Incrementing Packet Data Port

This block lets a host reach the bytes of a small packet buffer memory through a narrow register window instead of a flat address map. The memory holds a fixed number of pages, each 2048 bytes by default. A 16-bit pointer register chooses which page is reached and at which byte offset. The host then reads or writes through a four-byte data window.

Bit 15 of the pointer chooses the page. When set, accesses go to the page at the head of the receive queue. When clear, they go to the page the host placed in its packet-number register. Both page numbers come in as inputs from the queue and allocator logic outside this block.

Bit 14 turns on auto-increment. Each data byte then uses the current offset and afterwards advances the offset by one, wrapping inside the offset field and leaving the upper pointer bits alone. Without auto-increment, the window byte index is added to the offset and the pointer is left as it is.

The host issues byte, half-word or word requests. The block splits each one into single-byte operations at consecutive window addresses, least significant byte first, one per cycle. It returns one response when the last byte completes.

Top module: `pkt_window_port`

## Requirements
- R1: After reset the pointer reads as zero, `busy` is low and `rsp_valid` is low.
- R2: Window address 0 is the pointer low byte and address 1 is the pointer high byte. A write to either byte changes only that byte.
- R3: A read of the pointer high byte returns the stored byte ANDed with 0xF7, so pointer bit 11 always reads as zero.
- R4: Pointer bit 15 = 1 directs data accesses to the page on `rx_head_page`. Bit 15 = 0 directs them to the page on `host_page`.
- R5: With pointer bit 14 = 1, a data byte uses offset = pointer[10:0] and then sets pointer[10:0] to (offset + 1) mod 2048. Pointer bits [15:11] are unchanged, and the window byte index is ignored.
- R6: With pointer bit 14 = 0, a data byte at window address 4+i (i = 0..3) uses offset (pointer[10:0] + i) mod 2048, and the pointer is not modified.
- R7: `req_size` 0, 1 and 2 mean 1, 2 and 4 bytes. Byte k goes to window address (`req_addr` + k) mod 8. Read byte k lands in `rsp_rdata[8k+7:8k]`.
- R8: For an n-byte request accepted at clock edge E0, `busy` is high after E0 through edge En, and `rsp_valid` pulses for one cycle after edge En+1. Requests presented while `busy` is high are ignored.
- R9: Window addresses 2 and 3 read as zero, and writes to them change nothing.
- R10: Data written through the window is read back unchanged from the same page and offset. Memory read data reaches the response one cycle after the byte operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_addr | input | 3 | Starting window address (0/1 pointer, 2/3 reserved, 4-7 data) |
| req_wdata | input | 32 | Write data, least significant byte first |
| rx_head_page | input | PAGE_W | Page at the head of the receive queue |
| host_page | input | PAGE_W | Page from the host packet-number register |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data (zero for writes) |

## Verification
The bench aims at the following corner cases:

- **Offset wrap without auto-increment.** A word write that straddles the end of a page must wrap to offset 0. A design that carried into the page number would corrupt a neighbouring page.
- **Auto-increment wrap.** The increment must wrap from 2047 with bits 15 and 11 set. A design with a full 16-bit adder would clear or flip those control bits, and the pointer read-back would show it.
- **Window index in auto-increment mode.** The bench writes through a non-zero window address in auto-increment mode. A design that still added the window index would put the byte at the wrong offset.
- **Masked read and ignored inputs.** The bench checks the masked high-byte read and the reserved addresses. It also checks that a request injected while busy is dropped: one that slipped through would show up as a changed pointer.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

    localparam int PTR_W          = 16;
    localparam int SEL_BIT        = 15;
    localparam int INC_BIT        = 14;
    localparam int DEF_PAGES      = 4;
    localparam int DEF_PAGE_BYTES = 2048;
    localparam logic [7:0] HIGH_MASK = 8'hF7;

    typedef enum logic [1:0] {
        TGT_PTR_LO = 2'd0,
        TGT_PTR_HI = 2'd1,
        TGT_NONE   = 2'd2,
        TGT_DATA   = 2'd3
    } tgt_e;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic [2:0] addr;
        logic [7:0] wdata;
    } byte_op_t;

    function automatic tgt_e decode_target(input logic [2:0] a);
        if (a[2])          return TGT_DATA;
        else if (a == 3'd0) return TGT_PTR_LO;
        else if (a == 3'd1) return TGT_PTR_HI;
        else               return TGT_NONE;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pdp_splitter.sv
module pdp_splitter
    import pdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [2:0]  req_addr,
    input  logic [31:0] req_wdata,
    input  logic [7:0]  ret_byte,
    output logic        busy,
    output byte_op_t    op,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);

    logic        active;
    logic        wr_q;
    logic [2:0]  base_q;
    logic [31:0] wdata_q;
    logic [2:0]  cnt_q;
    logic [2:0]  k_q;
    logic        pend_valid;
    logic        pend_last;
    logic        pend_wr;
    logic [1:0]  pend_k;
    logic [31:0] acc_q;
    logic [31:0] merged;
    logic        accept;
    logic        last_now;

    assign accept   = req_valid && !busy;
    assign busy     = active || pend_valid;
    assign last_now = active && (3'(k_q + 3'd1) == cnt_q);

    assign op.valid = active;
    assign op.write = wr_q;
    assign op.addr  = 3'(base_q + k_q);
    assign op.wdata = 8'(wdata_q >> {k_q[1:0], 3'b000});

    always_comb begin
        merged = acc_q;
        merged[{pend_k, 3'b000} +: 8] = ret_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            wr_q       <= 1'b0;
            base_q     <= '0;
            wdata_q    <= '0;
            cnt_q      <= '0;
            k_q        <= '0;
            pend_valid <= 1'b0;
            pend_last  <= 1'b0;
            pend_wr    <= 1'b0;
            pend_k     <= '0;
            acc_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            if (accept) begin
                active  <= 1'b1;
                wr_q    <= req_write;
                base_q  <= req_addr;
                wdata_q <= req_wdata;
                cnt_q   <= size_bytes(req_size);
                k_q     <= '0;
                acc_q   <= '0;
            end else if (active) begin
                k_q <= 3'(k_q + 3'd1);
                if (last_now) active <= 1'b0;
            end
            pend_valid <= active;
            pend_last  <= last_now;
            pend_wr    <= wr_q;
            pend_k     <= k_q[1:0];
            if (pend_valid && !pend_wr) acc_q <= merged;
            rsp_valid <= pend_valid && pend_last;
            if (pend_valid && pend_last) rsp_rdata <= pend_wr ? 32'h0 : merged;
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);                          // R8
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (k_q < cnt_q));                          // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !accept) |=> !busy);                      // R8

endmodule

// File: rtl/pdp_pointer.sv
module pdp_pointer
    import pdp_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int OFF_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_op_t          op,
    input  logic [PAGE_W-1:0] rx_head_page,
    input  logic [PAGE_W-1:0] host_page,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PAGE_W-1:0] ram_page,
    output logic [OFF_W-1:0]  ram_off,
    output logic [7:0]        ram_wbyte,
    output logic [7:0]        ptr_rbyte
);

    logic [PTR_W-1:0] ptr_q;
    logic [OFF_W-1:0] cur_off;
    logic             auto_inc;
    logic             data_op;
    tgt_e             tgt;

    assign tgt      = decode_target(op.addr);
    assign data_op  = op.valid && (tgt == TGT_DATA);
    assign cur_off  = ptr_q[OFF_W-1:0];
    assign auto_inc = ptr_q[INC_BIT];

    assign ram_en    = data_op;
    assign ram_we    = op.write;
    assign ram_wbyte = op.wdata;
    assign ram_page  = ptr_q[SEL_BIT] ? rx_head_page : host_page;
    assign ram_off   = auto_inc ? cur_off : OFF_W'(cur_off + OFF_W'(op.addr[1:0]));

    always_comb begin
        case (tgt)
            TGT_PTR_LO: ptr_rbyte = ptr_q[7:0];
            TGT_PTR_HI: ptr_rbyte = ptr_q[15:8] & HIGH_MASK;
            default:    ptr_rbyte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (op.valid && op.write && tgt == TGT_PTR_LO) begin
            ptr_q[7:0] <= op.wdata;
        end else if (op.valid && op.write && tgt == TGT_PTR_HI) begin
            ptr_q[15:8] <= op.wdata;
        end else if (data_op && auto_inc) begin
            ptr_q[OFF_W-1:0] <= OFF_W'(cur_off + 1'b1);
        end
    end

    AST_PTR_STILL: assert property (@(posedge clk) disable iff (rst)
        (data_op && !auto_inc) |=> $stable(ptr_q));                       // R6
    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (data_op && auto_inc) |=>
        (ptr_q[OFF_W-1:0] == OFF_W'($past(ptr_q[OFF_W-1:0]) + 1'b1)));   // R5
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        data_op |=> (ptr_q[PTR_W-1:OFF_W] == $past(ptr_q[PTR_W-1:OFF_W]))); // R5
    AST_RSVD_NOP: assert property (@(posedge clk) disable iff (rst)
        (op.valid && tgt == TGT_NONE) |=> $stable(ptr_q));                // R9

endmodule

// File: rtl/pdp_page_ram.sv
module pdp_page_ram #(
    parameter int PAGE_W = 2,
    parameter int OFF_W  = 11
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  off,
    input  logic [7:0]        wbyte,
    output logic [7:0]        rbyte
);

    localparam int IDX_W = PAGE_W + OFF_W - 2;
    localparam int DEPTH = 2 ** IDX_W;

    logic [31:0]      mem [DEPTH];
    logic [31:0]      word_q;
    logic [1:0]       lane_q;
    logic [IDX_W-1:0] idx;
    logic [1:0]       lane;

    assign idx  = {page, off[OFF_W-1:2]};
    assign lane = off[1:0];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[idx][{lane, 3'b000} +: 8] <= wbyte;
        end
        if (en && !we) begin
            word_q <= mem[idx];
            lane_q <= lane;
        end
    end

    assign rbyte = 8'(word_q >> {lane_q, 3'b000});

endmodule

// File: rtl/pkt_window_port.sv
module pkt_window_port
    import pdp_pkg::*;
#(
    parameter  int PAGES      = DEF_PAGES,
    parameter  int PAGE_BYTES = DEF_PAGE_BYTES,
    localparam int PAGE_W     = $clog2(PAGES),
    localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [2:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [PAGE_W-1:0] rx_head_page,
    input  logic [PAGE_W-1:0] host_page,
    output logic              busy,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    byte_op_t          op;
    logic              ram_en;
    logic              ram_we;
    logic [PAGE_W-1:0] ram_page;
    logic [OFF_W-1:0]  ram_off;
    logic [7:0]        ram_wbyte;
    logic [7:0]        ram_rbyte;
    logic [7:0]        ptr_rbyte;
    logic [7:0]        ptr_rd_q;
    logic              from_ram_q;
    logic [7:0]        ret_byte;

    pdp_splitter u_split (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ret_byte  (ret_byte),
        .busy      (busy),
        .op        (op),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    pdp_pointer #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ptr (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .rx_head_page (rx_head_page),
        .host_page    (host_page),
        .ram_en       (ram_en),
        .ram_we       (ram_we),
        .ram_page     (ram_page),
        .ram_off      (ram_off),
        .ram_wbyte    (ram_wbyte),
        .ptr_rbyte    (ptr_rbyte)
    );

    pdp_page_ram #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .page  (ram_page),
        .off   (ram_off),
        .wbyte (ram_wbyte),
        .rbyte (ram_rbyte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_rd_q   <= '0;
            from_ram_q <= 1'b0;
        end else begin
            ptr_rd_q   <= ptr_rbyte;
            from_ram_q <= ram_en && !ram_we;
        end
    end

    assign ret_byte = from_ram_q ? ram_rbyte : ptr_rd_q;

    AST_RAM_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> (op.valid && op.addr[2]));               // R10

endmodule

// File: tb/pkt_window_port_test.sv
module pkt_window_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [1:0]  req_size;
    logic [2:0]  req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  rx_head_page;
    logic [1:0]  host_page;
    logic        busy;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mptr;
    logic [7:0]  mmem [int];

    always #2 clk = ~clk;

    pkt_window_port uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rx_head_page(rx_head_page), .host_page(host_page),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one request: returns expected data and known-byte mask.
    task automatic model(input bit wr, input logic [1:0] sz, input logic [2:0] ad,
                         input logic [31:0] wd, output logic [31:0] exp,
                         output logic [31:0] mask);
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        exp = 0; mask = 0;
        for (int k = 0; k < n; k++) begin
            int a = (ad + k) % 8;
            logic [7:0] b = wd[8*k +: 8];
            logic [7:0] r = 8'h00;
            bit known = 1;
            if (a == 0) begin
                if (wr) mptr[7:0] = b; else r = mptr[7:0];
            end else if (a == 1) begin
                if (wr) mptr[15:8] = b; else r = mptr[15:8] & 8'hF7;
            end else if (a >= 4) begin
                int pg = mptr[15] ? int'(rx_head_page) : int'(host_page);
                int off = mptr[14] ? int'(mptr[10:0]) : (int'(mptr[10:0]) + a - 4) % 2048;
                int key = pg * 2048 + off;
                if (wr) mmem[key] = b;
                else if (mmem.exists(key)) r = mmem[key];
                else known = 0;
                if (mptr[14]) mptr[10:0] = 11'((off + 1) % 2048);
            end
            exp[8*k +: 8] = r;
            if (known) mask[8*k +: 8] = 8'hFF;
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input logic [2:0] ad,
                          input logic [31:0] wd, input bit inject, input string tag,
                          output logic [31:0] got);
        logic [31:0] exp, mask;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        model(wr, sz, ad, wd, exp, mask);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        if (inject) begin
            req_valid = 1; req_write = 1; req_size = 0; req_addr = 0; req_wdata = 32'h99;
        end
        chk(busy === 1'b1 && rsp_valid === 1'b0, "R8", "start busy/rsp",
            {30'b0, busy, rsp_valid}, 32'h2);
        for (int i = 1; i <= n + 1; i++) begin
            @(negedge clk);
            req_valid = 0;
            chk(busy === (i <= n) && rsp_valid === (i == n + 1), "R8", "cycle busy/rsp",
                {30'b0, busy, rsp_valid}, {30'b0, 1'(i <= n), 1'(i == n + 1)});
        end
        if (!wr)
            chk((rsp_rdata & mask) === (exp & mask), tag, "read data",
                rsp_rdata & mask, exp & mask);
        got = rsp_rdata;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [2:0] ad, input logic [31:0] wd,
                      input string tag);
        logic [31:0] g;
        access(1, sz, ad, wd, 0, tag, g);
    endtask

    task automatic rd(input logic [1:0] sz, input logic [2:0] ad, input string tag);
        logic [31:0] g;
        access(0, sz, ad, 0, 0, tag, g);
    endtask

    initial begin
        req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
        rx_head_page = 2; host_page = 1; mptr = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(busy === 1'b0 && rsp_valid === 1'b0, "R1", "reset outputs",
            {30'b0, busy, rsp_valid}, 0);
        rd(1, 0, "R1");                          // pointer reads zero

        // R2: independent pointer byte writes
        wr(0, 0, 32'h34, "R2"); wr(0, 1, 32'h12, "R2");
        rd(1, 0, "R2");
        wr(0, 0, 32'hAB, "R2");
        rd(1, 0, "R2");

        // R3: high byte masked
        wr(0, 1, 32'hFF, "R3");
        rd(0, 1, "R3");

        // R6/R7: fixed pointer, window index added, LSB first
        wr(1, 0, 32'h0010, "R6");
        wr(2, 4, 32'hDDCCBBAA, "R7");
        rd(1, 0, "R6");                          // pointer unchanged
        rd(2, 4, "R7");
        rd(0, 6, "R6");
        rd(1, 5, "R7");

        // R6: straddle end of page wraps to offset 0
        wr(1, 0, 32'h07FE, "R6");
        wr(2, 4, 32'h44332211, "R6");
        rd(2, 4, "R6");
        wr(1, 0, 32'h0000, "R6");
        rd(1, 4, "R6");                          // offsets 0,1

        // R5: auto-increment, window index ignored
        wr(1, 0, 32'h4020, "R5");
        wr(2, 4, 32'h87654321, "R5");
        rd(1, 0, "R5");
        wr(1, 0, 32'h4020, "R5");
        wr(0, 6, 32'h5A, "R5");
        wr(1, 0, 32'h4020, "R5");
        rd(2, 4, "R5");
        rd(1, 0, "R5");

        // R5/R4: wrap at 2047 with control bits 15 and 11 kept, receive page
        wr(1, 0, 32'hCFFF, "R5");
        wr(1, 4, 32'hBEEF, "R5");
        rd(1, 0, "R5");
        wr(1, 0, 32'hCFFF, "R4");
        rd(1, 4, "R4");

        // R4: page select by bit 15, same offset different pages
        wr(1, 0, 32'h0100, "R4");
        wr(0, 4, 32'h11, "R4");
        wr(1, 0, 32'h8100, "R4");
        wr(0, 4, 32'h22, "R4");
        rd(0, 4, "R4");
        wr(1, 0, 32'h0100, "R4");
        rd(0, 4, "R4");
        host_page = 3;
        wr(0, 4, 32'h33, "R4");
        rd(0, 4, "R4");

        // R9: reserved addresses
        wr(0, 2, 32'h55, "R9");
        wr(1, 2, 32'hA5A5, "R9");
        rd(2, 0, "R9");                          // bytes 0..3: ptr lo, hi, 0, 0
        rd(1, 2, "R9");

        // R8: request injected while busy is dropped
        begin
            logic [31:0] g;
            access(0, 2, 4, 0, 1, "R8", g);
        end
        rd(1, 0, "R8");

        // R10: data integrity across many offsets with auto-increment
        host_page = 0;
        wr(1, 0, 32'h4300, "R10");
        for (int j = 0; j < 8; j++) wr(2, 4, 32'h01020304 * (j + 1), "R10");
        wr(1, 0, 32'h4300, "R10");
        for (int j = 0; j < 8; j++) rd(2, 4, "R10");
        rd(2, 7, "R7");                          // wraps window addresses 7,0,1,2

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R8 actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule